// File: doc/BRIEF.md
# Write-Completion Status Poller

This block runs on the host side of a byte-wide flash memory. After software has launched a program or erase, a start pulse hands it the byte that was written and a mode select. It then reads one location of the flash, one read at a time, until the status bits show that the internal write has ended.

In data-complement mode, bit 7 of the returned byte reads as the inverse of the written bit while the write is busy. In toggle mode, bit 6 flips between back-to-back reads while busy.

The flash finishes its write at a time the host does not control. A status read can therefore land on the moment of completion and return mixed data. For that reason an apparent completion is never reported at once. The poller makes two more reads of the same location and reports a pass only if both are valid. Otherwise the write is rejected. A poll budget bounds the busy phase and ends the run with a timeout flag. Generating the bus-level timing is left to the read port's owner.

Top module: `wr_status_poller`

## Requirements
- R1: While reset is held and just after it is released, `rd_req`, `done`, `pass` and `timeout` are all 0.
- R2: A `start` pulse seen while idle makes `rd_req` high in the next cycle for exactly one cycle. No further request is raised until `rd_valid` has returned the data of the outstanding read.
- R3: With `toggle_mode`=0, a polling read counts as an apparent completion when its bit 7 equals bit 7 of `exp_data`.
- R4: With `toggle_mode`=1, a polling read counts as an apparent completion when its bit 6 equals bit 6 of the read just before it in the same run. The first read of a run can never count.
- R5: After an apparent completion, exactly two confirmation reads are made. The run passes only if both return a byte equal to `exp_data`. In toggle mode, each must also have bit 6 equal to the read just before it.
- R6: A confirmation read that is not valid ends the run at once, with `pass`=0 and `timeout`=0.
- R7: If POLL_LIMIT polling reads give no apparent completion, the run ends with `timeout`=1 and `pass`=0. An apparent completion on read POLL_LIMIT still goes on to confirmation.
- R8: `done` is a one-cycle pulse in the cycle after the edge that samples the deciding read. `pass` and `timeout` take their result at that same edge and hold it until the next accepted `start`.
- R9: A `start` pulse while a run is in progress is ignored. The run's reads and result are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll run (accepted only when idle) |
| exp_data | input | 8 | Byte that was written, latched at start |
| toggle_mode | input | 1 | 0: bit-7 complement polling, 1: bit-6 toggle polling |
| rd_req | output | 1 | One-cycle request for a read of the polled location |
| rd_valid | input | 1 | Read data is present on `rd_data` |
| rd_data | input | 8 | Byte returned by the read |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Write confirmed complete and correct |
| timeout | output | 1 | Poll budget exhausted |

## Verification
A request is due one cycle after the accepting `start` edge, or one cycle after the edge that samples the previous read. `done`, `pass` and `timeout` are due one cycle after the edge that samples the deciding read. The bench drives inputs and samples outputs on falling edges. It returns each read a chosen number of cycles after seeing `rd_req`, and looks for `done` on the exact falling edge that follows the sampled read. A bench-side model of the rules predicts the number of reads and the result for each stream. Streams are swept over both modes, many written bytes, busy lengths that include the budget edge, confirmation failures in either slot, and read latencies of one to three cycles.

// File: rtl/wr_status_poller.sv
module wr_status_poller #(
  parameter int POLL_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] exp_data,
  input  logic       toggle_mode,
  output logic       rd_req,
  input  logic       rd_valid,
  input  logic [7:0] rd_data,
  output logic       done,
  output logic       pass,
  output logic       timeout
);
  localparam int CW = $clog2(POLL_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(POLL_LIMIT - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t        state;
  logic          confirming, second, have_prev, prev6, mode_q;
  logic [7:0]    exp_q;
  logic [CW-1:0] poll_cnt;

  wire steady   = have_prev && (rd_data[6] == prev6);
  wire apparent = mode_q ? steady : (rd_data[7] == exp_q[7]);
  wire good     = (rd_data == exp_q) && (!mode_q || steady);
  wire sample   = (state == S_WAIT) && rd_valid;

  assign rd_req = (state == S_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      confirming <= 1'b0;
      second <= 1'b0;
      have_prev <= 1'b0;
      prev6 <= 1'b0;
      mode_q <= 1'b0;
      exp_q <= '0;
      poll_cnt <= '0;
      done <= 1'b0;
      pass <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_REQ;
          mode_q <= toggle_mode;
          exp_q <= exp_data;
          confirming <= 1'b0;
          second <= 1'b0;
          have_prev <= 1'b0;
          poll_cnt <= '0;
          pass <= 1'b0;
          timeout <= 1'b0;
        end
        S_REQ: state <= S_WAIT;
        default: if (sample) begin
          prev6 <= rd_data[6];
          have_prev <= 1'b1;
          state <= S_REQ;
          if (!confirming) begin
            if (apparent) begin
              confirming <= 1'b1;
              second <= 1'b0;
            end else if (poll_cnt == LAST) begin
              state <= S_IDLE;
              done <= 1'b1;
              timeout <= 1'b1;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end else if (!good) begin
            state <= S_IDLE;
            done <= 1'b1;
          end else if (second) begin
            state <= S_IDLE;
            done <= 1'b1;
            pass <= 1'b1;
          end else begin
            second <= 1'b1;
          end
        end
      endcase
    end
  end

  a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_timeout_fails: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !pass);
  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass) |-> (done || $past(start)));
  a_r2_no_req_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);
endmodule

// File: tb/test_wr_status_poller.sv
module test_wr_status_poller;
  localparam int LIM = 16;

  logic clk = 0, rst_n = 0, start = 0, toggle_mode = 0, rd_valid = 0;
  logic [7:0] exp_data = 0, rd_data = 0;
  logic rd_req, done, pass, timeout;
  int total = 0, bad = 0;
  logic [7:0] stream [0:63];

  always #5 clk = ~clk;

  wr_status_poller #(.POLL_LIMIT(LIM)) i_wr_status_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_data(exp_data),
    .toggle_mode(toggle_mode), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .pass(pass), .timeout(timeout));

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Reference rules from the requirements: number of reads, pass, timeout
  task automatic model(input logic mode, input logic [7:0] e,
                       output int n, output int p, output int t);
    int polls = 0;
    int conf = 0;
    logic hp = 0;
    logic p6 = 0;
    p = 0; t = 0; n = 0;
    for (int i = 0; i < 64; i++) begin
      logic [7:0] d = stream[i];
      logic st = hp && (d[6] == p6);
      n++;
      hp = 1; p6 = d[6];
      if (conf == 0) begin
        polls++;
        if (mode ? st : (d[7] == e[7])) conf = 1;
        else if (polls == LIM) begin t = 1; return; end
      end else begin
        if (!((d == e) && (!mode || st))) return;
        if (conf == 2) begin p = 1; return; end
        conf = 2;
      end
    end
  endtask

  task automatic run(input logic mode, input logic [7:0] e, input int lat,
                     input bit poke, input string tag);
    int n, p, t, idx, cyc;
    bit got;
    model(mode, e, n, p, t);
    @(negedge clk);
    exp_data = e; toggle_mode = mode; start = 1;
    @(negedge clk);
    start = 0;
    check({tag, " R2 first request"}, rd_req, 1);
    idx = 0; cyc = 0; got = 0;
    while (!got && cyc < 3000) begin
      cyc++;
      if (done) got = 1;
      else if (rd_req) begin
        repeat (lat) begin
          @(negedge clk);
          if (rd_req) check({tag, " R2 request while outstanding"}, 1, 0);
        end
        rd_data = stream[idx < 64 ? idx : 63];
        rd_valid = 1;
        if (poke && idx == 1) start = 1;
        idx++;
        @(negedge clk);
        rd_valid = 0; start = 0;
        if (idx == n) check({tag, " R8 done one cycle after last read"}, done, 1);
      end else @(negedge clk);
    end
    check({tag, " R5/R6/R7 read count"}, idx, n);
    check({tag, " R3/R4/R5 pass"}, pass, p);
    check({tag, " R7 timeout"}, timeout, t);
    if (poke) check({tag, " R9 start while busy ignored"}, pass * 2 + timeout, p * 2 + t);
    @(negedge clk);
    check({tag, " R8 done is a pulse"}, done, 0);
    repeat (3) @(negedge clk);
    check({tag, " R8 result held"}, pass * 2 + timeout, p * 2 + t);
    check({tag, " R2 idle after end"}, rd_req, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] ev [0:5];
    ev[0] = 8'h00; ev[1] = 8'h5A; ev[2] = 8'hA5; ev[3] = 8'hFF; ev[4] = 8'h80; ev[5] = 8'h7F;
    repeat (3) @(negedge clk);
    check("R1 rd_req in reset", rd_req, 0);
    check("R1 done in reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 pass/timeout after reset", pass + timeout, 0);
    check("R1 rd_req after reset", rd_req, 0);

    // R3: complement polling, busy length sweep incl. budget edge, R5 pass
    for (int ei = 0; ei < 6; ei++)
      for (int k = 0; k < LIM + 2; k++) begin
        for (int i = 0; i < 64; i++)
          stream[i] = (i < k) ? {~ev[ei][7], ev[ei][6:0] ^ 7'(i)} : ev[ei];
        run(1'b0, ev[ei], 1 + (k % 3), 1'b0, "R3 sweep");
      end
    // R6: confirmation failures in slot 1 and slot 2
    for (int ei = 0; ei < 6; ei++)
      for (int slot = 1; slot <= 2; slot++) begin
        for (int i = 0; i < 64; i++)
          stream[i] = (i < 2) ? {~ev[ei][7], ev[ei][6:0]} : ev[ei];
        stream[2 + slot] = ev[ei] ^ 8'h01;
        run(1'b0, ev[ei], slot, 1'b0, "R6 race");
      end
    // R4: toggle polling, DQ6 alternates while busy
    for (int ei = 0; ei < 6; ei++)
      for (int k = 0; k < LIM + 3; k++) begin
        for (int i = 0; i < 64; i++)
          stream[i] = (i < k) ? {ev[ei][7] ^ 1'b1, 1'(i), ev[ei][5:0]} : ev[ei];
        run(1'b1, ev[ei], 1 + (k % 3), 1'b0, "R4 sweep");
      end
    // R4/R6: toggle steady but wrong data, and toggle in a confirmation slot
    for (int ei = 0; ei < 6; ei++) begin
      for (int i = 0; i < 64; i++) stream[i] = {ev[ei][7:1], ~ev[ei][0]};
      run(1'b1, ev[ei], 2, 1'b0, "R6 toggle wrong data");
      for (int i = 0; i < 64; i++) stream[i] = ev[ei];
      stream[3] = ev[ei] ^ 8'h40;
      run(1'b1, ev[ei], 1, 1'b0, "R6 toggle in confirm");
    end
    // R7: never completes in either mode
    for (int i = 0; i < 64; i++) stream[i] = 8'h7F ^ {1'b0, 1'(i), 6'd0};
    run(1'b0, 8'hC3, 1, 1'b0, "R7 timeout data-complement");
    run(1'b1, 8'hC3, 2, 1'b0, "R7 timeout toggle");
    // R9: start pulse in mid-run
    for (int i = 0; i < 64; i++) stream[i] = (i < 4) ? 8'h15 : 8'h95;
    run(1'b0, 8'h95, 2, 1'b1, "R9 busy start");
    for (int i = 0; i < 64; i++) stream[i] = (i < 5) ? {1'b0, 1'(i), 6'd3} : 8'h03;
    run(1'b1, 8'h03, 1, 1'b1, "R9 busy start toggle");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule